// File: doc/BRIEF.md
# Beam Spill Time-Structure Histogrammer

This block records how detector activity is spread in time across a beam spill. A beam-start pulse opens a new spill: every histogram is wiped, and each structure channel waits out its own programmable offset, counted in ticks of an external 100 ns timebase. It then counts hits into consecutive time bins. Each bin lasts for the channel's sample-period setting in ticks. When the last bin closes, the channel stops counting until the next beam-start pulse.

There are two general structure channels, A and B. Each has its own offset, its own period and a source select that picks either the OR of the start-counter channels or the time-of-flight/resistive-plate multiplicity signal. There is also one structure per start-counter input. These per-input structures share a global offset and a global period.

The same timebase drives a beam-length counter. When the programmed beam length expires, the block raises a no-beam inhibit level and holds it until the next beam-start pulse. Software reads every bin through one flat address space with a one-cycle read port.

Top module: `spill_hist_top`

## Requirements
- R1: After reset, `inhibit` and `rd_valid` are 0 and every bin reads back as 0.
- R2: Channel A counts a clock cycle as a hit when its select is 0 and any `hit_start` bit is high, or when its select is 1 and `hit_mult` is high. Channel B works the same way with its own select. Channel A occupies addresses 0..NUM_BINS-1 and channel B occupies NUM_BINS..2*NUM_BINS-1.
- R3: Let k be the number of clock edges with `tick` high since the beam-start edge, counted strictly before the current edge. A hit counts in bin (k-offset)/period, using integer division, when k >= offset. A hit with k < offset is not counted.
- R4: A period setting of 0 behaves exactly like a period of 1.
- R5: A clock edge with `beam_start` high clears every bin of every channel and restarts all offset counters. A hit in that same cycle is not counted. Hits whose bin index would be NUM_BINS or more are ignored.
- R6: The beam-length count starts at 0 on the beam-start edge and advances on each tick. `inhibit` goes high after the edge at which the tick count reaches `beam_len`, provided `beam_len` is not 0. It then stays high until the next beam-start edge, which clears it. When `beam_len` is 0, `inhibit` never rises.
- R7: A bin count saturates at 2^CNT_W-1 and does not wrap.
- R8: A read with `rd_en` high returns `rd_data` and `rd_valid`=1 one cycle later. An address at or beyond (2+NUM_START)*NUM_BINS reads as 0, and `rd_valid` is 0 one cycle after a cycle with `rd_en` low.
- R9: Start input i has its own structure at addresses (2+i)*NUM_BINS and up. It counts `hit_start[i]` using the global offset and the global period.
- R10: Before the first beam-start pulse after reset, hits are not counted and `inhibit` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| beam_start | input | 1 | beam-start pulse, one cycle |
| tick | input | 1 | 100 ns timebase tick, one cycle |
| hit_start | input | NUM_START | start-counter hit inputs |
| hit_mult | input | 1 | time-of-flight/resistive-plate multiplicity hit |
| src_sel_a | input | 1 | channel A source: 0 start OR, 1 multiplicity |
| src_sel_b | input | 1 | channel B source: 0 start OR, 1 multiplicity |
| ofs_a | input | OFS_W | channel A offset in ticks |
| ofs_b | input | OFS_W | channel B offset in ticks |
| ofs_glb | input | OFS_W | shared offset of the per-input structures |
| per_a | input | PER_W | channel A bin width in ticks |
| per_b | input | PER_W | channel B bin width in ticks |
| per_glb | input | PER_W | shared bin width of the per-input structures |
| beam_len | input | LEN_W | beam length in ticks, 0 disables inhibit |
| rd_en | input | 1 | read strobe |
| rd_addr | input | ADDR_W | flat bin address |
| rd_valid | output | 1 | read data valid |
| rd_data | output | CNT_W | bin count read back |
| inhibit | output | 1 | no-beam inhibit level |

## Verification
The assertions check the following on every cycle:
- the inhibit level clears on a beam-start edge, holds once set, rises only on a tick edge, and never rises while the length is 0;
- the read port answers with `rd_valid` one cycle after `rd_en`, and returns 0 for out-of-range addresses;
- channel A's bin index holds steady between ticks and returns to 0 on a beam start.

The actual bin contents can only be shown by the bench's scenarios, which replay known hit patterns and read every bin back. These cover:
- the offset and period arithmetic;
- source selection;
- zero periods;
- hits on the beam-start cycle and beyond the last bin;
- clearing by a new spill;
- counter saturation.

// File: rtl/spill_hist_pkg.sv
package spill_hist_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_OFFSET = 2'd1,
      PH_BIN    = 2'd2,
      PH_DONE   = 2'd3
   } phase_t;

   function automatic int sel_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/spill_bin_timer.sv
module spill_bin_timer
   import spill_hist_pkg::*;
#(
   parameter int NUM_BINS = 500,
   parameter int OFS_W    = 16,
   parameter int PER_W    = 16,
   localparam int BIN_W   = $clog2(NUM_BINS),
   localparam int TC_W    = sel_max(OFS_W, PER_W) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick,
   input  logic [OFS_W-1:0] offset,
   input  logic [PER_W-1:0] period,
   output logic             open,
   output logic [BIN_W-1:0] bin
);
   phase_t            phase;
   logic [TC_W-1:0]   tcnt;
   logic [TC_W-1:0]   tcnt_nx;
   logic [PER_W-1:0]  per_eff;
   logic              last_bin;

   assign tcnt_nx  = tcnt + 1'b1;
   assign per_eff  = (period == '0) ? PER_W'(1) : period;
   assign last_bin = (bin == BIN_W'(NUM_BINS - 1));
   assign open     = (phase == PH_BIN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         tcnt  <= '0;
         bin   <= '0;
      end else if (restart) begin
         tcnt  <= '0;
         bin   <= '0;
         phase <= (offset == '0) ? PH_BIN : PH_OFFSET;
      end else if (tick) begin
         case (phase)
            PH_OFFSET: begin
               if (tcnt_nx == TC_W'(offset)) begin
                  phase <= PH_BIN;
                  tcnt  <= '0;
               end else begin
                  tcnt <= tcnt_nx;
               end
            end
            PH_BIN: begin
               if (tcnt_nx == TC_W'(per_eff)) begin
                  tcnt <= '0;
                  if (last_bin) phase <= PH_DONE;
                  else          bin   <= bin + 1'b1;
               end else begin
                  tcnt <= tcnt_nx;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/spill_bin_store.sv
module spill_bin_store #(
   parameter int NUM_BINS = 500,
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1,
   localparam int BIN_W   = $clog2(NUM_BINS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             inc,
   input  logic [BIN_W-1:0] bin,
   input  logic [BIN_W-1:0] rd_addr,
   output logic [CNT_W-1:0] rd_word
);
   logic [CNT_W-1:0]    mem [NUM_BINS];
   logic [NUM_BINS-1:0] vld;
   logic [CNT_W-1:0]    cur;
   logic [CNT_W-1:0]    nxt;

   assign cur = vld[bin] ? mem[bin] : '0;

   generate
      if (SATURATE) begin : g_sat
         assign nxt = (cur == {CNT_W{1'b1}}) ? cur : cur + 1'b1;
      end else begin : g_wrap
         assign nxt = cur + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (inc && !clear) mem[bin] <= nxt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) vld <= '0;
      else if (inc)        vld[bin] <= 1'b1;
   end

   assign rd_word = vld[rd_addr] ? mem[rd_addr] : '0;
endmodule

// File: rtl/spill_inhibit_gen.sv
module spill_inhibit_gen #(
   parameter int LEN_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick,
   input  logic [LEN_W-1:0] beam_len,
   output logic             inhibit
);
   logic [LEN_W-1:0] lcnt;
   logic             armed;
   logic [LEN_W:0]   lcnt_nx;

   assign lcnt_nx = (LEN_W+1)'(lcnt) + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lcnt    <= '0;
         armed   <= 1'b0;
         inhibit <= 1'b0;
      end else if (restart) begin
         lcnt    <= '0;
         armed   <= 1'b1;
         inhibit <= 1'b0;
      end else if (tick && armed && !inhibit) begin
         lcnt <= lcnt + 1'b1;
         if (beam_len != '0 && lcnt_nx >= (LEN_W+1)'(beam_len)) inhibit <= 1'b1;
      end
   end
endmodule

// File: rtl/spill_hist_top.sv
module spill_hist_top #(
   parameter int  NUM_BINS  = 500,
   parameter int  NUM_START = 8,
   parameter int  CNT_W     = 16,
   parameter int  OFS_W     = 16,
   parameter int  PER_W     = 16,
   parameter int  LEN_W     = 24,
   parameter bit  SATURATE  = 1'b1,
   localparam int NUM_CH    = 2 + NUM_START,
   localparam int TOTAL     = NUM_CH * NUM_BINS,
   localparam int ADDR_W    = $clog2(TOTAL),
   localparam int BIN_W     = $clog2(NUM_BINS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 beam_start,
   input  logic                 tick,
   input  logic [NUM_START-1:0] hit_start,
   input  logic                 hit_mult,
   input  logic                 src_sel_a,
   input  logic                 src_sel_b,
   input  logic [OFS_W-1:0]     ofs_a,
   input  logic [OFS_W-1:0]     ofs_b,
   input  logic [OFS_W-1:0]     ofs_glb,
   input  logic [PER_W-1:0]     per_a,
   input  logic [PER_W-1:0]     per_b,
   input  logic [PER_W-1:0]     per_glb,
   input  logic [LEN_W-1:0]     beam_len,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic                 rd_valid,
   output logic [CNT_W-1:0]     rd_data,
   output logic                 inhibit
);
   initial begin
      assert (NUM_BINS >= 2) else $error("NUM_BINS must be at least 2");
      assert (NUM_START >= 1) else $error("NUM_START must be at least 1");
      assert (CNT_W >= 2) else $error("CNT_W must be at least 2");
      assert (OFS_W >= 1 && PER_W >= 1 && LEN_W >= 1) else $error("setting widths must be positive");
   end

   logic [NUM_CH-1:0]             ch_hit;
   logic [NUM_CH-1:0]             ch_open;
   logic [NUM_CH-1:0]             rd_sel;
   logic [NUM_CH-1:0][BIN_W-1:0]  ch_bin;
   logic [NUM_CH-1:0][BIN_W-1:0]  rd_loc;
   logic [NUM_CH-1:0][OFS_W-1:0]  ch_ofs;
   logic [NUM_CH-1:0][PER_W-1:0]  ch_per;
   logic [NUM_CH-1:0][CNT_W-1:0]  ch_word;
   logic [CNT_W-1:0]              rd_mux;
   logic                          start_any;

   assign start_any = |hit_start;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         localparam int BASE = c * NUM_BINS;

         if (c == 0) begin : g_a
            assign ch_hit[c] = src_sel_a ? hit_mult : start_any;
            assign ch_ofs[c] = ofs_a;
            assign ch_per[c] = per_a;
         end else if (c == 1) begin : g_b
            assign ch_hit[c] = src_sel_b ? hit_mult : start_any;
            assign ch_ofs[c] = ofs_b;
            assign ch_per[c] = per_b;
         end else begin : g_in
            assign ch_hit[c] = hit_start[c-2];
            assign ch_ofs[c] = ofs_glb;
            assign ch_per[c] = per_glb;
         end

         assign rd_sel[c] = (int'(rd_addr) >= BASE) && (int'(rd_addr) < BASE + NUM_BINS);
         assign rd_loc[c] = BIN_W'(rd_addr - ADDR_W'(BASE));

         spill_bin_timer #(
            .NUM_BINS (NUM_BINS),
            .OFS_W    (OFS_W),
            .PER_W    (PER_W)
         ) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (beam_start),
            .tick    (tick),
            .offset  (ch_ofs[c]),
            .period  (ch_per[c]),
            .open    (ch_open[c]),
            .bin     (ch_bin[c])
         );

         spill_bin_store #(
            .NUM_BINS (NUM_BINS),
            .CNT_W    (CNT_W),
            .SATURATE (SATURATE)
         ) u_mem (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (beam_start),
            .inc     (ch_open[c] && ch_hit[c]),
            .bin     (ch_bin[c]),
            .rd_addr (rd_loc[c]),
            .rd_word (ch_word[c])
         );
      end
   endgenerate

   spill_inhibit_gen #(
      .LEN_W (LEN_W)
   ) u_inh (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (beam_start),
      .tick     (tick),
      .beam_len (beam_len),
      .inhibit  (inhibit)
   );

   always_comb begin
      rd_mux = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (rd_sel[c]) rd_mux = rd_mux | ch_word[c];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= rd_mux;
      end
   end
endmodule

// File: rtl/spill_hist_chk.sv
module spill_hist_chk #(
   parameter int NUM_BINS = 500,
   parameter int CNT_W    = 16,
   parameter int LEN_W    = 24,
   parameter int TOTAL    = 5000,
   parameter int ADDR_W   = 13,
   parameter int BIN_W    = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              beam_start,
   input logic              tick,
   input logic [LEN_W-1:0]  beam_len,
   input logic              inhibit,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_valid,
   input logic [CNT_W-1:0]  rd_data,
   input logic              open_a,
   input logic [BIN_W-1:0]  bin_a
);
   p_inh_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      beam_start |=> !inhibit);

   p_inh_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit && !beam_start |=> inhibit);

   p_inh_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !inhibit && !tick |=> !inhibit);

   p_inh_len0_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !inhibit && beam_len == '0 |=> !inhibit);

   p_rd_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   p_rd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

   p_rd_oob_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && int'(rd_addr) >= TOTAL |=> rd_data == '0);

   p_bin_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      open_a && !tick && !beam_start |=> open_a && $stable(bin_a));

   p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      beam_start |=> bin_a == '0);

   initial begin
      assert (NUM_BINS >= 2) else $error("checker: NUM_BINS too small");
   end
endmodule

bind spill_hist_top spill_hist_chk #(
   .NUM_BINS (NUM_BINS),
   .CNT_W    (CNT_W),
   .LEN_W    (LEN_W),
   .TOTAL    (TOTAL),
   .ADDR_W   (ADDR_W),
   .BIN_W    (BIN_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .beam_start (beam_start),
   .tick       (tick),
   .beam_len   (beam_len),
   .inhibit    (inhibit),
   .rd_en      (rd_en),
   .rd_addr    (rd_addr),
   .rd_valid   (rd_valid),
   .rd_data    (rd_data),
   .open_a     (ch_open[0]),
   .bin_a      (ch_bin[0])
);

// File: tb/sim_spill_hist_top.sv
`timescale 1ns/1ps
module sim_spill_hist_top;
   localparam int NB    = 500;
   localparam int NS    = 8;
   localparam int CW    = 16;
   localparam int NCH   = 2 + NS;
   localparam int TOTAL = NCH * NB;
   localparam int AW    = $clog2(TOTAL);
   localparam int CMAX  = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          beam_start = 1'b0;
   logic          tick = 1'b0;
   logic [NS-1:0] hit_start = '0;
   logic          hit_mult = 1'b0;
   logic          sa = 1'b0, sb = 1'b0;
   logic [15:0]   oa = '0, ob = '0, og = '0;
   logic [15:0]   pa = 16'd1, pb = 16'd1, pg = 16'd1;
   logic [23:0]   bl = '0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          rd_valid;
   logic [CW-1:0] rd_data;
   logic          inhibit;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int exp_cnt [NCH][NB];
   int k_ticks = 0;
   bit started = 1'b0;
   bit e_inh   = 1'b0;

   always #2.5 clk = ~clk;

   spill_hist_top u0 (
      .clk(clk), .rst_n(rst_n), .beam_start(beam_start), .tick(tick),
      .hit_start(hit_start), .hit_mult(hit_mult),
      .src_sel_a(sa), .src_sel_b(sb),
      .ofs_a(oa), .ofs_b(ob), .ofs_glb(og),
      .per_a(pa), .per_b(pb), .per_glb(pg),
      .beam_len(bl), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_valid(rd_valid), .rd_data(rd_data), .inhibit(inhibit)
   );

   function automatic int bin_of(input int k, input int ofs, input int per);
      int p = (per == 0) ? 1 : per;
      if (k < ofs) return -1;
      return (k - ofs) / p;
   endfunction

   function automatic bit ch_hit(input int c, input logic [NS-1:0] hs, input logic hm);
      if (c == 0) return sa ? hm : (|hs);
      if (c == 1) return sb ? hm : (|hs);
      return hs[c-2];
   endfunction

   function automatic int ch_ofs(input int c);
      return (c == 0) ? int'(oa) : (c == 1) ? int'(ob) : int'(og);
   endfunction

   function automatic int ch_per(input int c);
      return (c == 0) ? int'(pa) : (c == 1) ? int'(pb) : int'(pg);
   endfunction

   task automatic clear_model();
      for (int c = 0; c < NCH; c++)
         for (int b = 0; b < NB; b++) exp_cnt[c][b] = 0;
   endtask

   // one cycle: check inhibit from the previous edge, drive, predict the next edge
   task automatic step(input logic st, input logic tk, input logic [NS-1:0] hs, input logic hm);
      @(negedge clk);
      checks++;
      if (inhibit !== e_inh) begin
         fails++;
         $display("FAIL R6 inhibit got=%0b exp=%0b", inhibit, e_inh);
      end
      beam_start = st; tick = tk; hit_start = hs; hit_mult = hm;
      if (st) begin
         clear_model();
         k_ticks = 0; started = 1'b1; e_inh = 1'b0;
      end else if (started) begin
         for (int c = 0; c < NCH; c++) begin
            if (ch_hit(c, hs, hm)) begin
               int b = bin_of(k_ticks, ch_ofs(c), ch_per(c));
               if (b >= 0 && b < NB && exp_cnt[c][b] < CMAX) exp_cnt[c][b]++;
            end
         end
         if (tk) begin
            k_ticks++;
            if (bl != 0 && k_ticks >= int'(bl)) e_inh = 1'b1;
         end
      end
   endtask

   task automatic idle();
      step(1'b0, 1'b0, '0, 1'b0);
   endtask

   task automatic read_all(input string tag);
      int bad [NCH];
      int fa [NCH];
      int fg [NCH];
      int fe [NCH];
      for (int c = 0; c < NCH; c++) bad[c] = 0;
      idle();
      for (int a = 0; a <= TOTAL; a++) begin
         @(negedge clk);
         if (a > 0) begin
            int c = (a - 1) / NB;
            int e = exp_cnt[c][(a - 1) % NB];
            if (!rd_valid || int'(rd_data) != e) begin
               if (bad[c] == 0) begin fa[c] = a - 1; fg[c] = int'(rd_data); fe[c] = e; end
               bad[c]++;
            end
         end
         if (a < TOTAL) begin rd_en = 1'b1; rd_addr = AW'(a); end
         else rd_en = 1'b0;
      end
      for (int c = 0; c < NCH; c++) begin
         checks++;
         if (bad[c] != 0) begin
            fails++;
            $display("FAIL %s ch%0d addr=%0d got=%0d exp=%0d (%0d bad)", tag, c, fa[c], fg[c], fe[c], bad[c]);
         end
      end
   endtask

   task automatic spill(input int cycles, input int tick_pct, input int hit_pct);
      step(1'b1, 1'b0, NS'($urandom), 1'b1);
      for (int i = 0; i < cycles; i++)
         step(1'b0, ($urandom % 100) < tick_pct,
              NS'($urandom) & ((($urandom % 100) < hit_pct) ? {NS{1'b1}} : NS'(0)),
              ($urandom % 100) < hit_pct);
   endtask

   initial begin
      void'($urandom(32'd20250611));
      clear_model();
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (inhibit !== 1'b0 || rd_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset inh=%0b vld=%0b exp=0/0", inhibit, rd_valid);
      end
      read_all("R1");

      // R10: activity before the first beam start
      sa = 1'b1; bl = 24'd3;
      for (int i = 0; i < 60; i++) step(1'b0, 1'b1, 8'hFF, 1'b1);
      read_all("R10");

      // directed spill: offsets, periods, period 0 (R4), both sources (R2), global (R9)
      oa = 16'd2; pa = 16'd3; sa = 1'b0;
      ob = 16'd0; pb = 16'd0; sb = 1'b1;
      og = 16'd1; pg = 16'd2; bl = 24'd20;
      step(1'b1, 1'b1, 8'hFF, 1'b1);            // R5: hit on start cycle ignored
      for (int i = 0; i < 120; i++)
         step(1'b0, i[0], NS'(1 << (i % NS)), (i % 3) == 0);
      read_all("R3/R4/R2/R9");

      // R5: new start clears everything
      step(1'b1, 1'b0, '0, 1'b0);
      read_all("R5 clear");

      // R5: run past the last bin, one tick per cycle
      oa = 16'd0; pa = 16'd1; sa = 1'b1; ob = 16'd0; pb = 16'd2; sb = 1'b0;
      og = 16'd3; pg = 16'd1; bl = 24'd0;      // R6: length 0 never inhibits
      step(1'b1, 1'b0, '0, 1'b0);
      for (int i = 0; i < 700; i++) step(1'b0, 1'b1, 8'h81, 1'b1);
      read_all("R5 end");

      // constrained random spills
      for (int r = 0; r < 3; r++) begin
         oa = 16'($urandom % 8); ob = 16'($urandom % 8); og = 16'($urandom % 8);
         pa = 16'($urandom % 4); pb = 16'($urandom % 4); pg = 16'($urandom % 4);
         sa = 1'($urandom); sb = 1'($urandom);
         bl = (r == 1) ? 24'd0 : 24'(1 + $urandom % 300);
         spill(900, 60, 40);
         read_all("R3 random");
      end

      // R8: out-of-range reads
      for (int a = TOTAL; a < TOTAL + 4; a++) begin
         @(negedge clk); rd_en = 1'b1; rd_addr = AW'(a);
         @(negedge clk); rd_en = 1'b0;
         checks++;
         if (rd_valid !== 1'b1 || rd_data !== '0) begin
            fails++;
            $display("FAIL R8 oob addr=%0d got=%0d vld=%0b exp=0 vld=1", a, rd_data, rd_valid);
         end
      end
      @(negedge clk);
      checks++;
      if (rd_valid !== 1'b0) begin
         fails++;
         $display("FAIL R8 rd_valid got=%0b exp=0", rd_valid);
      end

      // R7: saturation in bin 0 of A and B
      oa = 16'd0; ob = 16'd0; pa = 16'd5; pb = 16'd5; sa = 1'b1; sb = 1'b1; bl = 24'd0;
      step(1'b1, 1'b0, '0, 1'b0);
      for (int i = 0; i < CMAX + 20; i++) step(1'b0, 1'b0, '0, 1'b1);
      read_all("R7");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired got=running exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule